// File: doc/BRIEF.md
# Per-Lane PHY Bring-Up Sequencer

This block sits in the fabric beside one lane of a PHY that is driven through a PIPE-style direct interface. It carries the lane from power-on to live traffic. It holds itself idle until the device reports that configuration is finished. It then releases the lane's PCS reset once the board reset and the PHY's per-lane link-ready signal are both high. After that it follows the PHY's handshake events in a fixed order: TX clock alive, reset exit, receiver detection, reference lock, data lock, RX clock alive, and finally the receive path leaving reset.

Transmit and receive are enabled at separate points. `tx_en` rises once receiver detection is confirmed. `rx_en` rises only after the whole receive chain is ready. `rx_take` qualifies each receive beat for the downstream datapath. Any loss of a prerequisite sends the lane back to idle. Each wait step has a programmable timeout that restarts the sequence and leaves a sticky error flag. The block also produces the power-down code for unused lanes, which follows the progress of a neighbouring group of lanes.

Top module: `lane_bringup_seq`

## Requirements
- R1: While `rst_n` is low or `init_done_n` is high, the block holds these values on every clock: `state_code`=0, `pcs_rst_n`=0, `tx_en`=0, `rx_en`=0 and `err_flag`=0. `pd_code` reads 2'b00 after such a reset.
- R2: The block leaves code 0 only on a clock where `board_rst_n` and `xfer_en` are both high, and it then moves to code 1. `pcs_rst_n` is high in every code other than 0.
- R3: Code 1 moves to code 2 on a clock with `txclk_ok` high. Code 2 moves to code 3 only on a falling edge of `phy_status`, meaning the input was high at the previous clock and is low at this clock.
- R4: In code 3, a rising edge of `phy_status` and a rising edge of `rx_status` must both be seen. They may come in either order or on the same clock. When the second one arrives, the state moves to code 4. A single pulse leaves the state at code 3. `tx_en` is high exactly in codes 4 to 8.
- R5: The receive chain is taken strictly in order: 4→5 on `cdr_ref_lock`, 5→6 on `cdr_data_lock`, 6→7 on `rxclk_ok`, and 7→8 on `rx_rstat_n` high. A data lock that arrives before the reference lock does not advance code 4. `rx_en` is high only in code 8.
- R6: `rx_take` equals `rx_en` AND `rx_rstat_n` AND (either bit of `rx_valid`), with no clock delay.
- R7: `pd_code` is 2'b00 until a clock on which any bit of `grp_exit` is high. From the next cycle it is 2'b11 and stays there until reset.
- R8: In any nonzero code, a clock with `board_rst_n` or `xfer_en` low returns the block to code 0. That same clock drops `pcs_rst_n`, `tx_en` and `rx_en`.
- R9: In codes 1 to 7 with `tmo_limit`=L≠0, a state that does not advance is held for exactly L cycles. The block then returns to code 0 and sets `err_flag`, which stays high until R1 reset. With L=0 the timeout is off.
- R10: When an abort (R8) or a normal advance falls on the same clock as timeout expiry, the abort or the advance wins and `err_flag` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Synchronous reset, active low |
| init_done_n | input | 1 | Device configuration finished when low; high holds the block idle |
| board_rst_n | input | 1 | Board-level reset, high when released |
| xfer_en | input | 1 | PHY per-lane link-ready indication |
| phy_status | input | 1 | PHY per-lane status line |
| rx_status | input | 1 | PHY per-lane receive status line |
| txclk_ok | input | 1 | TX clock from the PHY is running |
| cdr_ref_lock | input | 1 | CDR locked to reference |
| cdr_data_lock | input | 1 | CDR locked to received data |
| rxclk_ok | input | 1 | RX clock from the PHY is running |
| rx_rstat_n | input | 1 | Receive path reset status, high when out of reset |
| rx_valid | input | 2 | Receive data valid qualifiers |
| grp_exit | input | GRP | Reset-exit flags of the lanes that govern unused-lane power-down |
| tmo_limit | input | TMO_W | Timeout length in cycles, 0 disables |
| pcs_rst_n | output | 1 | Lane PCS reset to the PHY, active low |
| tx_en | output | 1 | Transmit data allowed |
| rx_en | output | 1 | Receive path ready |
| rx_take | output | 1 | Sample this receive beat |
| pd_code | output | 2 | Power-down code for an unused lane |
| err_flag | output | 1 | Sticky timeout error |
| state_code | output | 4 | Current step, 0 to 8 |

## Verification
Two kinds of collision matter here. The first is the pair of detection pulses landing on one clock: the bench raises `phy_status` and `rx_status` together and expects code 4 at the next sample. The second is timeout expiry landing on the same clock as an abort or an advance. The bench counts cycles with a limit of 2 and drops `board_rst_n` or raises `txclk_ok` exactly on the expiry clock. It then expects code 0 or code 2 with `err_flag` still low. The timeout length itself is measured by counting the cycles spent in code 1 for L from 1 to 4.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_TXCLK    = 4'd1,
    ST_EXIT     = 4'd2,
    ST_DETECT   = 4'd3,
    ST_REFLOCK  = 4'd4,
    ST_DATALOCK = 4'd5,
    ST_RXCLK    = 4'd6,
    ST_RXRST    = 4'd7,
    ST_RUN      = 4'd8
  } lbs_state_e;

  // states in which the timeout counter runs
  function automatic logic is_wait(input lbs_state_e s);
    return (s != ST_IDLE) && (s != ST_RUN);
  endfunction

  // transmit window: from detection confirmed onward
  function automatic logic tx_window(input lbs_state_e s);
    return (s >= ST_REFLOCK);
  endfunction

endpackage

// File: rtl/lbs_sampler.sv
module lbs_sampler #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         srst,
  input  logic [N-1:0] din,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (srst) q[i] <= 1'b0;
      else      q[i] <= din[i];
    end
  end
endmodule

// File: rtl/lbs_wait_timer.sv
module lbs_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         srst,
  input  logic         run,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt;

  // expiry on the L-th cycle spent in one state
  function automatic logic hit(input logic [W-1:0] c, input logic [W-1:0] lim);
    return (lim != '0) && (c == lim - ONE);
  endfunction

  always_ff @(posedge clk) begin
    if (srst || clr || !run) cnt <= '0;
    else                     cnt <= cnt + ONE;
  end

  assign expire = run && hit(cnt, limit);
endmodule

// File: rtl/lbs_pd_ctrl.sv
module lbs_pd_ctrl #(
  parameter int GRP = 8
) (
  input  logic           clk,
  input  logic           srst,
  input  logic [GRP-1:0] grp_exit,
  output logic [1:0]     pd_code
);
  logic seen;

  always_ff @(posedge clk) begin
    if (srst) seen <= 1'b0;
    else      seen <= seen | (|grp_exit);
  end

  assign pd_code = seen ? 2'b11 : 2'b00;
endmodule

// File: rtl/lane_bringup_seq.sv
module lane_bringup_seq
  import lbs_pkg::*;
#(
  parameter int GRP   = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_done_n,
  input  logic             board_rst_n,
  input  logic             xfer_en,
  input  logic             phy_status,
  input  logic             rx_status,
  input  logic             txclk_ok,
  input  logic             cdr_ref_lock,
  input  logic             cdr_data_lock,
  input  logic             rxclk_ok,
  input  logic             rx_rstat_n,
  input  logic [1:0]       rx_valid,
  input  logic [GRP-1:0]   grp_exit,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             pcs_rst_n,
  output logic             tx_en,
  output logic             rx_en,
  output logic             rx_take,
  output logic [1:0]       pd_code,
  output logic             err_flag,
  output logic [3:0]       state_code
);

  lbs_state_e st, seq_nxt, nxt;

  logic       srst;
  logic [1:0] prev;
  logic       ps_rise, ps_fall, rs_rise;
  logic       ps_seen, rs_seen, ps_got, rs_got;
  logic       lost, advance, expire, tmo_fire;

  assign srst = !rst_n || init_done_n;

  lbs_sampler #(.N(2)) u_smp (
    .clk  (clk),
    .srst (srst),
    .din  ({rx_status, phy_status}),
    .q    (prev)
  );

  assign ps_rise = phy_status & ~prev[0];
  assign ps_fall = ~phy_status & prev[0];
  assign rs_rise = rx_status & ~prev[1];
  assign ps_got  = ps_seen | ps_rise;
  assign rs_got  = rs_seen | rs_rise;

  always_comb begin
    seq_nxt = st;
    unique case (st)
      ST_IDLE:     if (board_rst_n && xfer_en) seq_nxt = ST_TXCLK;
      ST_TXCLK:    if (txclk_ok)               seq_nxt = ST_EXIT;
      ST_EXIT:     if (ps_fall)                seq_nxt = ST_DETECT;
      ST_DETECT:   if (ps_got && rs_got)       seq_nxt = ST_REFLOCK;
      ST_REFLOCK:  if (cdr_ref_lock)           seq_nxt = ST_DATALOCK;
      ST_DATALOCK: if (cdr_data_lock)          seq_nxt = ST_RXCLK;
      ST_RXCLK:    if (rxclk_ok)               seq_nxt = ST_RXRST;
      ST_RXRST:    if (rx_rstat_n)             seq_nxt = ST_RUN;
      ST_RUN:                                  seq_nxt = ST_RUN;
      default:                                 seq_nxt = ST_IDLE;
    endcase
  end

  assign lost     = (st != ST_IDLE) && (!board_rst_n || !xfer_en);
  assign advance  = (seq_nxt != st);
  assign tmo_fire = expire && !lost && !advance;

  always_comb begin
    if (lost || tmo_fire) nxt = ST_IDLE;
    else                  nxt = seq_nxt;
  end

  lbs_wait_timer #(.W(TMO_W)) u_tmr (
    .clk    (clk),
    .srst   (srst),
    .run    (is_wait(st)),
    .clr    (nxt != st),
    .limit  (tmo_limit),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    if (srst) begin
      st       <= ST_IDLE;
      ps_seen  <= 1'b0;
      rs_seen  <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      st       <= nxt;
      ps_seen  <= (st == ST_DETECT) && ps_got;
      rs_seen  <= (st == ST_DETECT) && rs_got;
      err_flag <= err_flag | tmo_fire;
    end
  end

  lbs_pd_ctrl #(.GRP(GRP)) u_pd (
    .clk      (clk),
    .srst     (srst),
    .grp_exit (grp_exit),
    .pd_code  (pd_code)
  );

  assign state_code = st;
  assign pcs_rst_n  = (st != ST_IDLE);
  assign tx_en      = tx_window(st);
  assign rx_en      = (st == ST_RUN);
  assign rx_take    = rx_en && rx_rstat_n && (|rx_valid);

endmodule

// File: rtl/lane_bringup_seq_chk.sv
module lane_bringup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       init_done_n,
  input logic       board_rst_n,
  input logic       xfer_en,
  input logic       rx_rstat_n,
  input logic       pcs_rst_n,
  input logic       tx_en,
  input logic       rx_en,
  input logic       rx_take,
  input logic [1:0] pd_code,
  input logic       err_flag,
  input logic [3:0] state_code,
  input logic       lost,
  input logic       tmo_fire
);
  logic srst;
  assign srst = !rst_n || init_done_n;

  assert_hold_R1: assert property (@(posedge clk)
    srst |=> (state_code == 4'd0 && !pcs_rst_n && !err_flag));

  assert_pcs_order_R2: assert property (@(posedge clk) disable iff (srst)
    $rose(pcs_rst_n) |-> ($past(board_rst_n) && $past(xfer_en)));

  assert_tx_gated_R4: assert property (@(posedge clk) disable iff (srst)
    tx_en |-> pcs_rst_n);

  assert_rx_after_tx_R5: assert property (@(posedge clk) disable iff (srst)
    rx_en |-> tx_en);

  assert_rx_entry_R5: assert property (@(posedge clk) disable iff (srst)
    $rose(rx_en) |-> $past(rx_rstat_n));

  assert_take_R6: assert property (@(posedge clk) disable iff (srst)
    rx_take |-> (rx_en && rx_rstat_n));

  assert_pd_hold_R7: assert property (@(posedge clk) disable iff (srst)
    (pd_code == 2'b11) |=> (pd_code == 2'b11));

  assert_pd_legal_R7: assert property (@(posedge clk) disable iff (srst)
    (pd_code == 2'b00) || (pd_code == 2'b11));

  assert_abort_R8: assert property (@(posedge clk) disable iff (srst)
    lost |=> (state_code == 4'd0 && !tx_en && !rx_en && !pcs_rst_n));

  assert_tmo_R9: assert property (@(posedge clk) disable iff (srst)
    tmo_fire |=> (err_flag && state_code == 4'd0));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (srst)
    err_flag |=> err_flag);

  assert_abort_no_err_R10: assert property (@(posedge clk) disable iff (srst)
    (lost && !err_flag) |=> !err_flag);

endmodule

bind lane_bringup_seq lane_bringup_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .init_done_n (init_done_n),
  .board_rst_n (board_rst_n),
  .xfer_en     (xfer_en),
  .rx_rstat_n  (rx_rstat_n),
  .pcs_rst_n   (pcs_rst_n),
  .tx_en       (tx_en),
  .rx_en       (rx_en),
  .rx_take     (rx_take),
  .pd_code     (pd_code),
  .err_flag    (err_flag),
  .state_code  (state_code),
  .lost        (lost),
  .tmo_fire    (tmo_fire)
);

// File: tb/lane_bringup_seq_test.sv
module lane_bringup_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int GRP        = 8;
  localparam int TMO_W      = 16;

  logic             clk = 1'b0;
  logic             rst_n, init_done_n, board_rst_n, xfer_en;
  logic             phy_status, rx_status, txclk_ok;
  logic             cdr_ref_lock, cdr_data_lock, rxclk_ok, rx_rstat_n;
  logic [1:0]       rx_valid;
  logic [GRP-1:0]   grp_exit;
  logic [TMO_W-1:0] tmo_limit;
  logic             pcs_rst_n, tx_en, rx_en, rx_take, err_flag;
  logic [1:0]       pd_code;
  logic [3:0]       state_code;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_bringup_seq #(.GRP(GRP), .TMO_W(TMO_W)) uut (
    .clk(clk), .rst_n(rst_n), .init_done_n(init_done_n),
    .board_rst_n(board_rst_n), .xfer_en(xfer_en),
    .phy_status(phy_status), .rx_status(rx_status), .txclk_ok(txclk_ok),
    .cdr_ref_lock(cdr_ref_lock), .cdr_data_lock(cdr_data_lock),
    .rxclk_ok(rxclk_ok), .rx_rstat_n(rx_rstat_n), .rx_valid(rx_valid),
    .grp_exit(grp_exit), .tmo_limit(tmo_limit),
    .pcs_rst_n(pcs_rst_n), .tx_en(tx_en), .rx_en(rx_en), .rx_take(rx_take),
    .pd_code(pd_code), .err_flag(err_flag), .state_code(state_code)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_phy();
    phy_status = 0; rx_status = 0; txclk_ok = 0;
    cdr_ref_lock = 0; cdr_data_lock = 0; rxclk_ok = 0;
    rx_rstat_n = 0; rx_valid = 2'b00;
  endtask

  // order 0: phystatus pulse first, 1: rx_status first, 2: same cycle
  task automatic bringup(input int order);
    board_rst_n = 1; xfer_en = 1; phy_status = 1;
    step(); chk("R2 enter code1", int'(state_code), 1);
    chk("R2 pcs released", int'(pcs_rst_n), 1);
    step(); chk("R3 wait txclk", int'(state_code), 1);
    txclk_ok = 1;
    step(); chk("R3 txclk advance", int'(state_code), 2);
    step(); chk("R3 no fall yet", int'(state_code), 2);
    phy_status = 0;
    step(); chk("R3 fall advance", int'(state_code), 3);
    if (order == 2) begin
      phy_status = 1; rx_status = 1;
      step(); chk("R4 same cycle", int'(state_code), 4);
      phy_status = 0; rx_status = 0;
    end else begin
      if (order == 0) phy_status = 1; else rx_status = 1;
      step(); chk("R4 one pulse holds", int'(state_code), 3);
      chk("R4 tx off", int'(tx_en), 0);
      phy_status = 0; rx_status = 0;
      step(); chk("R4 still detect", int'(state_code), 3);
      if (order == 0) rx_status = 1; else phy_status = 1;
      step(); chk("R4 pair done", int'(state_code), 4);
      phy_status = 0; rx_status = 0;
    end
    chk("R4 tx on", int'(tx_en), 1);
    cdr_data_lock = 1;
    step(); chk("R5 data lock early ignored", int'(state_code), 4);
    cdr_ref_lock = 1;
    step(); chk("R5 ref lock", int'(state_code), 5);
    step(); chk("R5 data lock", int'(state_code), 6);
    chk("R5 rx off", int'(rx_en), 0);
    rxclk_ok = 1;
    step(); chk("R5 rxclk", int'(state_code), 7);
    rx_valid = 2'b10;
    step(); chk("R6 take before ready", int'(rx_take), 0);
    chk("R5 rx still off", int'(rx_en), 0);
    rx_rstat_n = 1;
    step(); chk("R5 run", int'(state_code), 8);
    chk("R5 rx on", int'(rx_en), 1);
    chk("R6 take", int'(rx_take), 1);
    rx_valid = 2'b00; #1 chk("R6 no valid", int'(rx_take), 0);
    rx_valid = 2'b01; rx_rstat_n = 0; #1 chk("R6 rstat low", int'(rx_take), 0);
    rx_rstat_n = 1; #1 chk("R6 valid0", int'(rx_take), 1);
    if (order == 0) xfer_en = 0; else board_rst_n = 0;
    step(); chk("R8 abort code", int'(state_code), 0);
    chk("R8 pcs", int'(pcs_rst_n), 0);
    chk("R8 tx", int'(tx_en), 0);
    chk("R8 rx", int'(rx_en), 0);
    clear_phy(); board_rst_n = 0; xfer_en = 0;
    step();
  endtask

  initial begin
    rst_n = 0; init_done_n = 1; board_rst_n = 0; xfer_en = 0;
    clear_phy(); grp_exit = '0; tmo_limit = '0;
    repeat (3) step();
    chk("R1 reset code", int'(state_code), 0);
    chk("R1 reset pcs", int'(pcs_rst_n), 0);
    chk("R1 reset tx", int'(tx_en), 0);
    chk("R1 reset rx", int'(rx_en), 0);
    chk("R1 reset pd", int'(pd_code), 0);
    chk("R1 reset err", int'(err_flag), 0);

    rst_n = 1; board_rst_n = 1; xfer_en = 1;
    repeat (3) step();
    chk("R1 init not done", int'(state_code), 0);
    chk("R1 init not done pcs", int'(pcs_rst_n), 0);
    board_rst_n = 0; xfer_en = 0; init_done_n = 0;
    step(); chk("R1 released idle", int'(state_code), 0);

    board_rst_n = 1;
    step(); step(); chk("R2 xfer low", int'(state_code), 0);
    board_rst_n = 0; xfer_en = 1;
    step(); chk("R2 board low", int'(state_code), 0);

    board_rst_n = 1;
    step(); chk("R2 enter", int'(state_code), 1);
    repeat (20) step();
    chk("R9 limit zero holds", int'(state_code), 1);
    chk("R9 limit zero no err", int'(err_flag), 0);
    board_rst_n = 0;
    step(); chk("R8 abort code1", int'(state_code), 0);

    tmo_limit = 16'd2; board_rst_n = 1;
    step(); chk("R10 enter a", int'(state_code), 1);
    step(); chk("R10 hold a", int'(state_code), 1);
    board_rst_n = 0;
    step(); chk("R10 abort wins", int'(state_code), 0);
    chk("R10 abort no err", int'(err_flag), 0);
    board_rst_n = 1;
    step(); chk("R10 enter b", int'(state_code), 1);
    step(); chk("R10 hold b", int'(state_code), 1);
    txclk_ok = 1;
    step(); chk("R10 advance wins", int'(state_code), 2);
    chk("R10 advance no err", int'(err_flag), 0);
    board_rst_n = 0; xfer_en = 0; txclk_ok = 0; tmo_limit = '0;
    step();

    for (int o = 0; o < 3; o++) bringup(o);

    for (int lim = 1; lim <= 4; lim++) begin
      int n;
      tmo_limit = TMO_W'(lim); board_rst_n = 1; xfer_en = 1;
      step();
      n = 0;
      while (state_code == 4'd1 && n < 20) begin
        n++;
        step();
      end
      chk("R9 cycles in wait", n, lim);
      chk("R9 back to idle", int'(state_code), 0);
      chk("R9 err set", int'(err_flag), 1);
      board_rst_n = 0;
      step(); chk("R9 err sticky", int'(err_flag), 1);
    end
    tmo_limit = '0; xfer_en = 0;
    rst_n = 0; step(); rst_n = 1; step();
    chk("R1 reset clears err", int'(err_flag), 0);

    for (int b = 0; b < GRP; b++) begin
      rst_n = 0; grp_exit = '0; step();
      rst_n = 1; step();
      chk("R7 pd low", int'(pd_code), 0);
      grp_exit[b] = 1'b1;
      step(); chk("R7 pd high", int'(pd_code), 3);
      grp_exit = '0;
      step(); chk("R7 pd kept", int'(pd_code), 3);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule